// File: doc/BRIEF.md
# Request-Reply Sequencer with Frame Resynchronisation

This controller sits between an SPI target front end and the logic that consumes requests and produces replies. It runs a half-duplex exchange with a host. First it collects a request frame and forwards every received byte to a consumer port. Then it builds a reply, raises an attention interrupt toward the host, and streams the reply into the transmit path. It lowers the interrupt only when the host's read frame has really ended.

The front end provides two sticky flags, one for chip-select assertion and one for chip-select deassertion. It also provides a sticky receive-error flag, a receive FIFO whose entries carry a start-of-frame tag, and the live chip-select level.

A sticky end flag can be left over from an earlier frame. For that reason the sequencer never treats the flag alone as a frame boundary. It also requires the live chip-select line to be high. If the end flag is set while the line is still low, framing has been lost. The sequencer counts the event, waits for the line to rise, and then clears the whole front end in a single cycle. Lost leading bytes and receive overruns produce a flow-error reply. A lost request frame produces a desynchronisation reply.

Top module: `rrs_sequencer`

## Requirements
- R1: During reset, and after it until the live chip-select (active low) is seen high, `attn_irq` and `fe_clean` are held at 1. The cycle after chip-select high is sampled, both are 0.
- R2: Once `ssa_flag` is seen in idle, every receive FIFO entry is popped and presented on `req_data` with `req_valid`, in FIFO order. A clean request then gives one `req_done` pulse with `req_status` = 0.
- R3: A request frame ends only when the FIFO is empty, `ssd_flag` is set and `cs_n_live` is 1. If `ssd_flag` is set while `cs_n_live` is 0, the sequencer sends no reply, keeps `attn_irq` low and gives no `req_done` until `cs_n_live` rises.
- R4: A request frame lost that way completes with `req_status` = 2. Its reply is the version header followed by code byte 0x02. This takes priority over a flow error.
- R5: If `rx_err_flag` is set at any time during request collection, the request completes with `req_status` = 1 and the reply is the version header followed by code byte 0x01.
- R6: If the first popped entry of a request has `rx_sot` = 0, the request completes with `req_status` = 1 and the reply is the version header followed by 0x01.
- R7: Every reply starts with the protocol version (default 3) as 4 bytes, least significant byte first. A reply with status 0 continues with payload bytes taken from the payload port, up to and including the byte marked `pay_last`.
- R8: `attn_irq` rises when a reply starts loading. It stays high until the host's read frame ends with `ssd_flag` set and `cs_n_live` 1, and it never falls while `cs_n_live` is 0.
- R9: `fe_clean` is high for exactly one cycle after each completed request frame and one cycle after each completed reply frame.
- R10: `desync_cnt` increases by one for each `ssd_flag` seen while `cs_n_live` is low, in either phase, and holds at its maximum value.
- R11: `tx_push` is high only in cycles where `tx_ready` is high. A stalled transmit path does not change the reply contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n_live | input | 1 | Live chip-select level, active low, synchronised |
| ssa_flag | input | 1 | Sticky chip-select-asserted flag |
| ssd_flag | input | 1 | Sticky chip-select-deasserted flag |
| rx_err_flag | input | 1 | Sticky receive overrun/error flag |
| rx_valid | input | 1 | Receive FIFO not empty |
| rx_data | input | DW | Receive FIFO head byte |
| rx_sot | input | 1 | Head entry is the first byte after chip-select fell |
| rx_pop | output | 1 | Pop the receive FIFO head |
| fe_clean | output | 1 | Clear FIFOs, error flag and sticky select flags |
| req_valid | output | 1 | Request byte valid |
| req_data | output | DW | Request byte |
| req_done | output | 1 | Request frame complete (one cycle) |
| req_status | output | 2 | 0 ok, 1 flow error, 2 desynchronised |
| pay_valid | input | 1 | Reply payload byte available |
| pay_data | input | DW | Reply payload byte |
| pay_last | input | 1 | Current payload byte is the last one |
| pay_pop | output | 1 | Payload byte consumed |
| tx_ready | input | 1 | Transmit FIFO has room |
| tx_push | output | 1 | Write `tx_data` into the transmit FIFO |
| tx_data | output | DW | Reply byte |
| attn_irq | output | 1 | Attention interrupt toward the host |
| desync_cnt | output | CNT_W | Saturating count of desynchronisation events |

## Verification
The bench drives a model of the front end and sweeps every error mode against several request and payload lengths, with and without transmit back-pressure.

The main target is a stale end flag raised while chip-select is still low, in both the request and the reply phase. A design that trusted the flag would reply early, or drop the interrupt mid-frame, and would keep slipping by one frame on every later exchange.

The missing start tag and the overrun flag must give code 0x01 and not 0x02, and a combined overrun and lost frame must report 0x02. A byte-order mistake in the header shows up as a reply of 0,0,0,3. The counter runs in a narrow configuration so that a wrapping counter is seen to return to zero.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

   typedef enum logic [2:0] {
      ST_INIT,
      ST_IDLE,
      ST_RX,
      ST_HOLD,
      ST_CLEAN,
      ST_TX,
      ST_TXEND
   } seq_state_t;

   typedef enum logic [1:0] {
      RK_OK     = 2'd0,
      RK_FLOW   = 2'd1,
      RK_DESYNC = 2'd2
   } reply_kind_t;

endpackage

// File: rtl/rrs_sat_cnt.sv
module rrs_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] MAXV = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (inc && cnt != MAXV)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rrs_tx_mux.sv
module rrs_tx_mux #(
   parameter int          DW        = 8,
   parameter int          VER_BYTES = 4,
   parameter int unsigned VER       = 3,
   parameter logic [7:0]  FLOW_CODE = 8'h01,
   parameter logic [7:0]  DSY_CODE  = 8'h02,
   localparam int         IW        = $clog2(VER_BYTES + 1)
) (
   input  logic [IW-1:0]            idx,
   input  rrs_pkg::reply_kind_t     kind,
   input  logic [DW-1:0]            pay_data,
   output logic [DW-1:0]            byte_out
);
   logic [DW-1:0] hdr [VER_BYTES+1];

   for (genvar gi = 0; gi < VER_BYTES; gi++) begin : g_hdr
      localparam int SH = DW * gi;
      if (SH < 32) begin : g_in
         assign hdr[gi] = DW'(VER >> SH);
      end else begin : g_out
         assign hdr[gi] = '0;
      end
   end
   assign hdr[VER_BYTES] = '0;

   always_comb begin
      if (idx < IW'(VER_BYTES))
         byte_out = hdr[idx];
      else if (kind == rrs_pkg::RK_DESYNC)
         byte_out = DW'(DSY_CODE);
      else if (kind == rrs_pkg::RK_FLOW)
         byte_out = DW'(FLOW_CODE);
      else
         byte_out = pay_data;
   end
endmodule

// File: rtl/rrs_ctrl.sv
module rrs_ctrl #(
   parameter int VER_BYTES = 4,
   localparam int IW = $clog2(VER_BYTES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_n_live,
   input  logic                  ssa_flag,
   input  logic                  ssd_flag,
   input  logic                  rx_err_flag,
   input  logic                  rx_valid,
   input  logic                  rx_sot,
   input  logic                  tx_ready,
   input  logic                  pay_valid,
   input  logic                  pay_last,
   output logic                  rx_pop,
   output logic                  fe_clean,
   output logic                  req_done,
   output rrs_pkg::reply_kind_t  kind,
   output logic                  pay_pop,
   output logic                  tx_push,
   output logic                  attn,
   output logic                  desync_evt,
   output logic [IW-1:0]         idx
);
   import rrs_pkg::*;

   seq_state_t st;
   logic phase_tx, flow_q, dsy_q, first_q;
   logic in_hdr, need_pay, last_byte, end_seen;

   assign kind      = dsy_q ? RK_DESYNC : (flow_q ? RK_FLOW : RK_OK);
   assign in_hdr    = idx < IW'(VER_BYTES);
   assign need_pay  = !in_hdr && kind == RK_OK;
   assign last_byte = !in_hdr && (kind != RK_OK || pay_last);
   assign tx_push   = st == ST_TX && tx_ready && (!need_pay || pay_valid);
   assign pay_pop   = tx_push && need_pay;
   assign rx_pop    = st == ST_RX && rx_valid;
   assign fe_clean  = st == ST_INIT || st == ST_CLEAN;
   assign req_done  = st == ST_CLEAN && !phase_tx;
   assign attn      = st == ST_INIT || st == ST_TX || st == ST_TXEND ||
                      (st == ST_HOLD && phase_tx);
   assign end_seen  = (st == ST_RX && !rx_valid && ssd_flag) ||
                      ((st == ST_TX || st == ST_TXEND) && ssd_flag);
   assign desync_evt = end_seen && !cs_n_live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_INIT;
         phase_tx <= 1'b0;
         flow_q   <= 1'b0;
         dsy_q    <= 1'b0;
         first_q  <= 1'b0;
         idx      <= '0;
      end else begin
         unique case (st)
            ST_INIT:  if (cs_n_live) st <= ST_IDLE;
            ST_IDLE:  if (ssa_flag) begin
                         st       <= ST_RX;
                         phase_tx <= 1'b0;
                         flow_q   <= 1'b0;
                         dsy_q    <= 1'b0;
                         first_q  <= 1'b1;
                      end
            ST_RX: begin
               if (rx_valid) begin
                  first_q <= 1'b0;
                  if (first_q && !rx_sot) flow_q <= 1'b1;
               end
               if (rx_err_flag) flow_q <= 1'b1;
               if (end_seen) begin
                  if (cs_n_live) st <= ST_CLEAN;
                  else begin
                     dsy_q <= 1'b1;
                     st    <= ST_HOLD;
                  end
               end
            end
            ST_HOLD:  if (cs_n_live) st <= ST_CLEAN;
            ST_CLEAN: if (phase_tx) st <= ST_IDLE;
                      else begin
                         st       <= ST_TX;
                         phase_tx <= 1'b1;
                         idx      <= '0;
                      end
            ST_TX, ST_TXEND: begin
               if (tx_push) begin
                  if (last_byte) st <= ST_TXEND;
                  else if (in_hdr) idx <= idx + 1'b1;
               end
               if (end_seen) st <= cs_n_live ? ST_CLEAN : ST_HOLD;
            end
            default:  st <= ST_INIT;
         endcase
      end
   end
endmodule

// File: rtl/rrs_sequencer.sv
module rrs_sequencer #(
   parameter int          DW        = 8,
   parameter int          VER_BYTES = 4,
   parameter int unsigned VER       = 3,
   parameter int          CNT_W     = 16,
   parameter logic [7:0]  FLOW_CODE = 8'h01,
   parameter logic [7:0]  DSY_CODE  = 8'h02
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n_live,
   input  logic             ssa_flag,
   input  logic             ssd_flag,
   input  logic             rx_err_flag,
   input  logic             rx_valid,
   input  logic [DW-1:0]    rx_data,
   input  logic             rx_sot,
   output logic             rx_pop,
   output logic             fe_clean,
   output logic             req_valid,
   output logic [DW-1:0]    req_data,
   output logic             req_done,
   output logic [1:0]       req_status,
   input  logic             pay_valid,
   input  logic [DW-1:0]    pay_data,
   input  logic             pay_last,
   output logic             pay_pop,
   input  logic             tx_ready,
   output logic             tx_push,
   output logic [DW-1:0]    tx_data,
   output logic             attn_irq,
   output logic [CNT_W-1:0] desync_cnt
);
   localparam int IW = $clog2(VER_BYTES + 1);

   if (DW < 8) begin : g_bad_dw
      $error("rrs_sequencer: DW must be at least 8");
   end
   if (VER_BYTES < 1) begin : g_bad_ver
      $error("rrs_sequencer: VER_BYTES must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("rrs_sequencer: CNT_W must be at least 1");
   end

   rrs_pkg::reply_kind_t kind;
   logic [IW-1:0]        idx;
   logic                 desync_evt;

   rrs_ctrl #(.VER_BYTES(VER_BYTES)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_live  (cs_n_live),
      .ssa_flag   (ssa_flag),
      .ssd_flag   (ssd_flag),
      .rx_err_flag(rx_err_flag),
      .rx_valid   (rx_valid),
      .rx_sot     (rx_sot),
      .tx_ready   (tx_ready),
      .pay_valid  (pay_valid),
      .pay_last   (pay_last),
      .rx_pop     (rx_pop),
      .fe_clean   (fe_clean),
      .req_done   (req_done),
      .kind       (kind),
      .pay_pop    (pay_pop),
      .tx_push    (tx_push),
      .attn       (attn_irq),
      .desync_evt (desync_evt),
      .idx        (idx)
   );

   rrs_tx_mux #(
      .DW(DW), .VER_BYTES(VER_BYTES), .VER(VER),
      .FLOW_CODE(FLOW_CODE), .DSY_CODE(DSY_CODE)
   ) i_mux (
      .idx     (idx),
      .kind    (kind),
      .pay_data(pay_data),
      .byte_out(tx_data)
   );

   rrs_sat_cnt #(.W(CNT_W)) i_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (desync_evt),
      .cnt  (desync_cnt)
   );

   assign req_valid  = rx_pop;
   assign req_data   = rx_data;
   assign req_status = kind;
endmodule

// File: rtl/rrs_sequencer_chk.sv
module rrs_sequencer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n_live,
   input logic             attn_irq,
   input logic             tx_push,
   input logic             tx_ready,
   input logic             req_valid,
   input logic             req_done,
   input logic [CNT_W-1:0] desync_cnt
);
   // R8
   attn_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(attn_irq) |-> $past(cs_n_live));

   // R11
   tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> (tx_ready && attn_irq));

   // R2
   req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !attn_irq);

   // R3
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> $past(cs_n_live));

   // R10
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (desync_cnt == $past(desync_cnt)) ||
               ({1'b0, desync_cnt} == {1'b0, $past(desync_cnt)} + 1'b1));
endmodule

bind rrs_sequencer rrs_sequencer_chk #(.CNT_W(CNT_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n_live (cs_n_live),
   .attn_irq  (attn_irq),
   .tx_push   (tx_push),
   .tx_ready  (tx_ready),
   .req_valid (req_valid),
   .req_done  (req_done),
   .desync_cnt(desync_cnt)
);

// File: tb/test_rrs_sequencer.sv
module test_rrs_sequencer;
   localparam int CW = 3;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n_live = 1'b0;
   logic ssa_flag = 1'b0, ssd_flag = 1'b0, rx_err_flag = 1'b0;
   logic [7:0] fd [16];
   logic       fs [16];
   int         wr = 0, rd = 0;
   int         pidx = 0, mlen = 1;
   logic       throttle = 1'b0;
   logic       tx_ready = 1'b1;

   logic rx_valid, rx_sot, rx_pop, fe_clean, req_valid, req_done, pay_pop;
   logic tx_push, attn_irq, pay_valid, pay_last;
   logic [7:0] rx_data, req_data, pay_data, tx_data;
   logic [1:0] req_status;
   logic [CW-1:0] desync_cnt;

   assign rx_valid  = rd < wr;
   assign rx_data   = fd[rd[3:0]];
   assign rx_sot    = fs[rd[3:0]];
   assign pay_valid = 1'b1;
   assign pay_data  = 8'(8'hA0 ^ (pidx * 5 + mlen));
   assign pay_last  = pidx == mlen - 1;

   rrs_sequencer #(.CNT_W(CW)) i_rrs_sequencer (
      .clk(clk), .rst_n(rst_n), .cs_n_live(cs_n_live),
      .ssa_flag(ssa_flag), .ssd_flag(ssd_flag), .rx_err_flag(rx_err_flag),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_sot(rx_sot), .rx_pop(rx_pop),
      .fe_clean(fe_clean), .req_valid(req_valid), .req_data(req_data),
      .req_done(req_done), .req_status(req_status),
      .pay_valid(pay_valid), .pay_data(pay_data), .pay_last(pay_last),
      .pay_pop(pay_pop), .tx_ready(tx_ready), .tx_push(tx_push),
      .tx_data(tx_data), .attn_irq(attn_irq), .desync_cnt(desync_cnt)
   );

   always #5 clk = ~clk;

   int n_chk = 0, n_bad = 0;
   logic [7:0] reqbuf [32];
   logic [7:0] txbuf [32];
   int reqn = 0, txn = 0, dones = 0, cleans = 0, pushbad = 0;
   logic [1:0] lastst = 2'd0;

   // front-end model and monitor
   always @(posedge clk) begin
      if (fe_clean) begin
         ssa_flag <= 1'b0; ssd_flag <= 1'b0; rx_err_flag <= 1'b0;
         rd <= 0; wr <= 0;
      end else if (rx_pop) rd <= rd + 1;
      if (pay_pop) pidx <= pidx + 1;
      if (rst_n) begin
         if (req_valid) begin reqbuf[reqn % 32] = req_data; reqn++; end
         if (req_done) begin dones++; lastst = req_status; end
         if (tx_push) begin
            txbuf[txn % 32] = tx_data; txn++;
            if (!tx_ready) pushbad++;
         end
         if (fe_clean) cleans++;
      end
   end

   always @(negedge clk) tx_ready <= throttle ? ~tx_ready : 1'b1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   int ev = 0;
   function automatic int exp_cnt();
      return ev > CMAX ? CMAX : ev;
   endfunction

   task automatic run_exch(input int mode, input int n, input int m, input bit thr);
      int st_exp, len;
      logic [7:0] eb;
      @(negedge clk);
      throttle = thr; pidx = 0; mlen = m;
      reqn = 0; txn = 0; dones = 0; cleans = 0;
      for (int i = 0; i < n; i++) begin
         fd[i] = 8'(8'h10 + i * 7 + n);
         fs[i] = (i == 0) && (mode != 1);
      end
      wr = n;
      cs_n_live = 1'b0; ssa_flag = 1'b1;
      repeat (n + 3) @(negedge clk);
      if (mode == 2 || mode == 4) rx_err_flag = 1'b1;
      @(negedge clk);
      if (mode == 3 || mode == 4) begin
         ssd_flag = 1'b1;
         repeat (8) @(negedge clk);
         chk(attn_irq == 1'b0, "R3 attn held low while cs low", attn_irq, 0);
         chk(txn == 0, "R3 no reply before cs high", txn, 0);
         chk(dones == 0, "R3 no req_done before cs high", dones, 0);
         ev++;
         chk(desync_cnt == exp_cnt(), "R10 count after rx desync", desync_cnt, exp_cnt());
         cs_n_live = 1'b1;
      end else begin
         cs_n_live = 1'b1; ssd_flag = 1'b1;
      end
      repeat (40) @(negedge clk);
      st_exp = (mode == 3 || mode == 4) ? 2 : ((mode == 1 || mode == 2) ? 1 : 0);
      chk(dones == 1, "R2 one req_done", dones, 1);
      chk(lastst == 2'(st_exp), "R4/R5/R6 req_status", lastst, st_exp);
      if (st_exp != 2) begin
         chk(reqn == n, "R2 request byte count", reqn, n);
         for (int i = 0; i < n && i < reqn; i++)
            chk(reqbuf[i] == 8'(8'h10 + i * 7 + n), "R2 request byte",
                reqbuf[i], 8'(8'h10 + i * 7 + n));
      end
      chk(attn_irq == 1'b1, "R8 attn high during reply", attn_irq, 1);
      chk(cleans == 1, "R9 one clean after request", cleans, 1);
      len = (st_exp == 0) ? 4 + m : 5;
      chk(txn == len, "R7 reply length", txn, len);
      for (int i = 0; i < len && i < txn; i++) begin
         if (i == 0) eb = 8'd3;
         else if (i < 4) eb = 8'd0;
         else if (st_exp == 2) eb = 8'h02;
         else if (st_exp == 1) eb = 8'h01;
         else eb = 8'(8'hA0 ^ ((i - 4) * 5 + m));
         chk(txbuf[i] == eb, (i >= 4 && st_exp == 2) ? "R4 code byte" :
             (i >= 4 && st_exp == 1) ? "R5/R6 code byte" : "R7 reply byte",
             txbuf[i], eb);
      end
      // host reads the reply
      cs_n_live = 1'b0; ssa_flag = 1'b1;
      repeat (3) @(negedge clk);
      if (mode == 5) begin
         ssd_flag = 1'b1;
         repeat (6) @(negedge clk);
         chk(attn_irq == 1'b1, "R8 attn held while cs low", attn_irq, 1);
         ev++;
         chk(desync_cnt == exp_cnt(), "R10 count after tx desync", desync_cnt, exp_cnt());
         cs_n_live = 1'b1;
      end else begin
         cs_n_live = 1'b1; ssd_flag = 1'b1;
      end
      repeat (4) @(negedge clk);
      chk(attn_irq == 1'b0, "R8 attn released after frame", attn_irq, 0);
      chk(cleans == 2, "R9 one clean after reply", cleans, 2);
      chk(txn == len, "R11 no extra pushes", txn, len);
      chk(desync_cnt == exp_cnt(), "R10 counter value", desync_cnt, exp_cnt());
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) begin fd[i] = '0; fs[i] = 1'b0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(attn_irq == 1'b1, "R1 attn in reset", attn_irq, 1);
      chk(fe_clean == 1'b1, "R1 clean in reset", fe_clean, 1);
      chk(tx_push == 1'b0 && req_valid == 1'b0, "R1 quiet in reset", tx_push, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(attn_irq == 1'b1, "R1 attn held while cs low", attn_irq, 1);
      chk(fe_clean == 1'b1, "R1 clean held while cs low", fe_clean, 1);
      chk(desync_cnt == 0, "R10 counter reset", desync_cnt, 0);
      cs_n_live = 1'b1;
      @(negedge clk);
      chk(attn_irq == 1'b0, "R1 attn released", attn_irq, 0);
      chk(fe_clean == 1'b0, "R1 clean released", fe_clean, 0);
      // sweep: 0 ok, 1 no SOT, 2 rx error, 3 rx desync, 4 rx error + desync, 5 tx desync
      for (int mode = 0; mode < 6; mode++)
         for (int n = 1; n <= 4; n++)
            run_exch(mode, n, (n % 4) + 1, n[0]);
      chk(pushbad == 0, "R11 push only with tx_ready", pushbad, 0);
      chk(desync_cnt == CMAX, "R10 counter saturated", desync_cnt, CMAX);
      finish_run();
   end
endmodule